// File: doc/BRIEF.md
# Reader Front-End Phase Sequencer

This block is the control state machine of a low-frequency reader front end. A host steers it through one control line and nothing else. The block reads the line's level and edges. From them it derives every operating phase: sleep, wake-up, idle, the serial write of a 7-bit mode word, diagnosis, charge, the write/program gap and receive. Each phase lasts a number of clock cycles set by a parameter, so the same RTL can run with real-time constants or with short ones.

The mode word selects the carrier divider factor, or automatic tuning. It also picks synchronous or asynchronous byte output to the host and a fixed or automatic demodulator threshold, and it carries a flag saying that more bytes follow. At a fixed point in the diagnosis phase the block reports the antenna state as a one-byte code with a single-cycle strobe. The receive phase ends in one of three ways: a short timeout when no start byte was seen, a longer one when it was, or an abort requested by the host, which is guarded by a minimum low time. A phase code that cannot occur in normal operation sends the machine back to idle.

Top module: `tps_sequencer`

## Requirements
- R1: After a synchronous reset the phase output reads idle (code 2). The frequency code, sync, threshold and follow flags are all 0, the divider factor is 119, auto_tune is 0 and diag_valid is 0.
- R2: In idle (code 2), a control line that stays low for SLEEP_CYC consecutive cycles moves the phase to sleep (code 0).
- R3: In sleep, a falling edge on the control line starts wake-up (code 1). Wake-up lasts WAKE_CYC cycles and then returns to idle.
- R4: A high level in idle enters arming (code 3). If the line stays high for INIT_CYC cycles, the phase goes to diagnosis (code 5) and the mode word is left unchanged.
- R5: A low level during arming starts a mode write (code 4). The write is a grid of 8 cells of BIT_CYC cycles each, beginning at that start bit. The line is sampled once per cell, at cell cycle BIT_CYC/2. Cells 1 to 4 form the frequency code with cell 1 as LSB, cell 5 is sync_out, cell 6 is fixed_thresh and cell 7 is test_follow. The word is committed at the end of cell 7, and the phase then goes to diagnosis.
- R6: div_factor is 119 for frequency code 0 and for codes 12 to 15. Codes 1 to 11 give 113 plus the code, which is 114 to 124. auto_tune is 1 only for code 15.
- R7: DIAG_CYC cycles after diagnosis is entered, diag_valid is high for exactly one cycle. With it, diag_byte reads 0xFF if ant_fault was high at that point and 0xAF otherwise. With sync_out at 0 the phase goes to charge (code 6) in that same cycle.
- R8: With sync_out at 1, diagnosis lasts SYNC_CYC cycles before charge is entered.
- R9: In charge, a low line enters the gap phase (code 7). A high level in the gap enters write/program (code 8). A gap that stays low for GAP_CYC cycles enters receive (code 9). Write/program also enters receive once the line has been low for GAP_CYC cycles in a row.
- R10: Receive returns to idle RXS_CYC cycles after it is entered. If start_found was seen high during receive, the limit is RXL_CYC cycles instead.
- R11: A falling edge during receive ends it ABORT_CYC cycles later. If the line returns high before MINLOW_CYC low samples have been taken, the abort is cancelled.
- R12: The control line has no effect on the phase during diagnosis or during wake-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| ctl_line | input | 1 | Host control line |
| ant_fault | input | 1 | High when the antenna does not oscillate or is shorted |
| start_found | input | 1 | Demodulator pulse: start byte recognised |
| phase | output | 4 | Current phase code |
| freq_code | output | 4 | Frequency/threshold field of the mode word |
| sync_out | output | 1 | Synchronous host output selected |
| fixed_thresh | output | 1 | Fixed demodulator threshold selected |
| test_follow | output | 1 | Further bytes follow the mode word |
| div_factor | output | 7 | Carrier divider factor |
| auto_tune | output | 1 | Automatic carrier tuning requested |
| diag_byte | output | 8 | Antenna diagnosis code |
| diag_valid | output | 1 | One-cycle strobe for diag_byte |

## Verification
The bench shortens every timing constant: an 8-cycle bit cell, 6-cycle arming, 40-cycle sleep entry, 10-cycle wake-up, 12 and 20 cycle diagnosis, a 5-cycle gap, 60 and 120 cycle receive limits, and a 15-cycle abort with a 6-cycle minimum low time. With these values, sleep entry, both receive timeouts, a cancelled and a committed abort, and several complete mode writes all happen within a couple of thousand cycles. Together the writes cover the default code, the divider extremes, an undefined code and auto-tune.

// File: rtl/tps_pkg.sv
package tps_pkg;

    typedef enum logic [3:0] {
        PH_SLEEP  = 4'd0,
        PH_WAKE   = 4'd1,
        PH_IDLE   = 4'd2,
        PH_ARM    = 4'd3,
        PH_MCW    = 4'd4,
        PH_DIAG   = 4'd5,
        PH_CHARGE = 4'd6,
        PH_GAP    = 4'd7,
        PH_WRITE  = 4'd8,
        PH_RECV   = 4'd9
    } phase_e;

    // Mode word bits 7..1 in packed order (bit 0 is the start cell).
    typedef struct packed {
        logic       test_follow;
        logic       fixed_thresh;
        logic       sync_out;
        logic [3:0] freq_code;
    } mode_t;

    localparam int DIV_W = 7;
    localparam logic [DIV_W-1:0] DIV_DEFAULT = 7'd119;
    localparam logic [DIV_W-1:0] DIV_BASE    = 7'd113;
    localparam logic [3:0]       CODE_LAST   = 4'd11;
    localparam logic [3:0]       CODE_AUTO   = 4'hF;
    localparam logic [7:0]       DIAG_GOOD   = 8'hAF;
    localparam logic [7:0]       DIAG_BAD    = 8'hFF;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [DIV_W-1:0] div_of(input logic [3:0] code);
        if (code == 4'd0 || code > CODE_LAST)
            return DIV_DEFAULT;
        return DIV_BASE + {3'b000, code};
    endfunction

endpackage

// File: rtl/tps_mode_reg.sv
module tps_mode_reg
    import tps_pkg::*;
#(
    parameter int BIT_CYC = 64
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  active,
    input  logic  ctl,
    output logic  done,
    output mode_t mode
);
    localparam int CW = (BIT_CYC > 2) ? $clog2(BIT_CYC) : 1;
    localparam logic [CW-1:0] C_LAST = CW'(BIT_CYC - 1);
    localparam logic [CW-1:0] C_MID  = CW'(BIT_CYC / 2);

    logic [CW-1:0] cnt;
    logic [2:0]    idx;
    logic [7:1]    shadow;

    assign done = active && (idx == 3'd7) && (cnt == C_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            idx    <= '0;
            shadow <= '0;
            mode   <= '0;
        end else if (!active) begin
            cnt <= '0;
            idx <= '0;
        end else begin
            if (cnt == C_LAST) begin
                cnt <= '0;
                idx <= idx + 3'd1;
            end else begin
                cnt <= cnt + 1'b1;
            end
            if (cnt == C_MID) begin
                for (int i = 1; i < 8; i++) begin
                    if (idx == 3'(i)) shadow[i] <= ctl;
                end
            end
            if (done) mode <= mode_t'(shadow);
        end
    end

    // R5: the mode word moves only at the end of a complete write
    assert_mode_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(mode));

    // R5: a cell index never advances outside an active write
    assert_idle_grid_R5: assert property (@(posedge clk) disable iff (rst)
        !active |=> (idx == 3'd0));

endmodule

// File: rtl/tps_diag.sv
module tps_diag
    import tps_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fire,
    input  logic       fault,
    output logic       diag_valid,
    output logic [7:0] diag_byte
);
    always_ff @(posedge clk) begin
        if (rst) begin
            diag_valid <= 1'b0;
            diag_byte  <= '0;
        end else begin
            diag_valid <= fire;
            if (fire) diag_byte <= fault ? DIAG_BAD : DIAG_GOOD;
        end
    end

    // R7: a strobed byte is always one of the two legal codes
    assert_diag_code_R7: assert property (@(posedge clk) disable iff (rst)
        diag_valid |-> (diag_byte == DIAG_GOOD || diag_byte == DIAG_BAD));

    // R7: the strobe lasts a single cycle
    assert_diag_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        diag_valid |=> !diag_valid);

endmodule

// File: rtl/tps_rx_guard.sv
module tps_rx_guard #(
    parameter int ABORT_CYC  = 900,
    parameter int MINLOW_CYC = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic ctl,
    input  logic ctl_fall,
    input  logic start_found,
    output logic abort_now,
    output logic found
);
    localparam int AW = $clog2(ABORT_CYC + 1);
    localparam logic [AW-1:0] A_END = AW'(ABORT_CYC);
    localparam logic [AW-1:0] A_MIN = AW'(MINLOW_CYC);
    localparam logic [AW-1:0] A_ONE = AW'(1);

    logic          armed;
    logic [AW-1:0] acnt;

    assign abort_now = armed && (acnt == A_END);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            armed <= 1'b0;
            acnt  <= '0;
            found <= 1'b0;
        end else begin
            if (start_found) found <= 1'b1;
            if (!armed) begin
                if (ctl_fall) begin
                    armed <= 1'b1;
                    acnt  <= A_ONE;
                end
            end else if (ctl && acnt < A_MIN) begin
                armed <= 1'b0;
                acnt  <= '0;
            end else if (acnt != A_END) begin
                acnt <= acnt + 1'b1;
            end
        end
    end

    // R11: an expired abort leaves receive on the next cycle
    assert_abort_exit_R11: assert property (@(posedge clk) disable iff (rst)
        (active && abort_now) |=> !active);

    // R11: once armed, the guard count stays within its window
    assert_abort_window_R11: assert property (@(posedge clk) disable iff (rst)
        armed |-> (acnt != '0 && acnt <= A_END));

endmodule

// File: rtl/tps_sequencer.sv
module tps_sequencer
    import tps_pkg::*;
#(
    parameter int BIT_CYC    = 64,
    parameter int INIT_CYC   = 200,
    parameter int SLEEP_CYC  = 100000,
    parameter int WAKE_CYC   = 2000,
    parameter int DIAG_CYC   = 2000,
    parameter int SYNC_CYC   = 3000,
    parameter int GAP_CYC    = 100,
    parameter int RXS_CYC    = 4000,
    parameter int RXL_CYC    = 20000,
    parameter int ABORT_CYC  = 900,
    parameter int MINLOW_CYC = 128
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ctl_line,
    input  logic       ant_fault,
    input  logic       start_found,
    output logic [3:0] phase,
    output logic [3:0] freq_code,
    output logic       sync_out,
    output logic       fixed_thresh,
    output logic       test_follow,
    output logic [6:0] div_factor,
    output logic       auto_tune,
    output logic [7:0] diag_byte,
    output logic       diag_valid
);
    localparam int T_MAX = imax(imax(imax(SLEEP_CYC, RXL_CYC), imax(RXS_CYC, SYNC_CYC)),
                                imax(imax(DIAG_CYC, WAKE_CYC), imax(INIT_CYC, GAP_CYC)));
    localparam int TW = $clog2(T_MAX + 1);

    localparam logic [TW-1:0] L_WAKE  = TW'(WAKE_CYC - 1);
    localparam logic [TW-1:0] L_SLEEP = TW'(SLEEP_CYC - 1);
    localparam logic [TW-1:0] L_INIT  = TW'(INIT_CYC - 1);
    localparam logic [TW-1:0] L_DIAG  = TW'(DIAG_CYC - 1);
    localparam logic [TW-1:0] L_SYNC  = TW'(SYNC_CYC - 1);
    localparam logic [TW-1:0] L_GAP   = TW'(GAP_CYC - 1);
    localparam logic [TW-1:0] L_RXS   = TW'(RXS_CYC - 1);
    localparam logic [TW-1:0] L_RXL   = TW'(RXL_CYC - 1);

    phase_e        state, nstate;
    logic [TW-1:0] tmr;
    logic          ctl_q;
    logic          ctl_fall;
    logic          mcw_done;
    logic          diag_fire;
    logic          abort_now;
    logic          rx_found;
    mode_t         mode;

    assign ctl_fall  = ctl_q & ~ctl_line;
    assign diag_fire = (state == PH_DIAG) && (tmr == L_DIAG);

    always_comb begin
        nstate = state;
        unique case (state)
            PH_SLEEP:  if (ctl_fall) nstate = PH_WAKE;
            PH_WAKE:   if (tmr == L_WAKE) nstate = PH_IDLE;
            PH_IDLE:   if (ctl_line) nstate = PH_ARM;
                       else if (tmr == L_SLEEP) nstate = PH_SLEEP;
            PH_ARM:    if (!ctl_line) nstate = PH_MCW;
                       else if (tmr == L_INIT) nstate = PH_DIAG;
            PH_MCW:    if (mcw_done) nstate = PH_DIAG;
            PH_DIAG:   if (tmr == (mode.sync_out ? L_SYNC : L_DIAG)) nstate = PH_CHARGE;
            PH_CHARGE: if (!ctl_line) nstate = PH_GAP;
            PH_GAP:    if (ctl_line) nstate = PH_WRITE;
                       else if (tmr == L_GAP) nstate = PH_RECV;
            PH_WRITE:  if (!ctl_line && tmr == L_GAP) nstate = PH_RECV;
            PH_RECV:   if (abort_now || tmr == (rx_found ? L_RXL : L_RXS)) nstate = PH_IDLE;
            default:   nstate = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PH_IDLE;
            tmr   <= '0;
            ctl_q <= 1'b0;
        end else begin
            state <= nstate;
            ctl_q <= ctl_line;
            if (nstate != state || (state == PH_WRITE && ctl_line))
                tmr <= '0;
            else if (tmr != '1)
                tmr <= tmr + 1'b1;
        end
    end

    tps_mode_reg #(.BIT_CYC(BIT_CYC)) u_mode (
        .clk    (clk),
        .rst    (rst),
        .active (state == PH_MCW),
        .ctl    (ctl_line),
        .done   (mcw_done),
        .mode   (mode)
    );

    tps_diag u_diag (
        .clk        (clk),
        .rst        (rst),
        .fire       (diag_fire),
        .fault      (ant_fault),
        .diag_valid (diag_valid),
        .diag_byte  (diag_byte)
    );

    tps_rx_guard #(.ABORT_CYC(ABORT_CYC), .MINLOW_CYC(MINLOW_CYC)) u_guard (
        .clk         (clk),
        .rst         (rst),
        .active      (state == PH_RECV),
        .ctl         (ctl_line),
        .ctl_fall    (ctl_fall),
        .start_found (start_found),
        .abort_now   (abort_now),
        .found       (rx_found)
    );

    assign phase        = state;
    assign freq_code    = mode.freq_code;
    assign sync_out     = mode.sync_out;
    assign fixed_thresh = mode.fixed_thresh;
    assign test_follow  = mode.test_follow;
    assign div_factor   = div_of(mode.freq_code);
    assign auto_tune    = (mode.freq_code == CODE_AUTO);

    // R3: sleep is left only towards wake-up
    assert_sleep_exit_R3: assert property (@(posedge clk) disable iff (rst)
        (state == PH_SLEEP) |=> (state == PH_SLEEP || state == PH_WAKE));

    // R12: wake-up runs its full length whatever the line does
    assert_wake_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (state == PH_WAKE && tmr != L_WAKE) |=> (state == PH_WAKE));

    // R5: a mode write can only start from arming
    assert_mcw_entry_R5: assert property (@(posedge clk) disable iff (rst)
        (state != PH_ARM && state != PH_MCW) |=> (state != PH_MCW));

    // R10: receive only ever returns to idle
    assert_recv_exit_R10: assert property (@(posedge clk) disable iff (rst)
        (state == PH_RECV) |=> (state == PH_RECV || state == PH_IDLE));

    // R7: the diagnosis strobe appears only right after diagnosis
    assert_diag_place_R7: assert property (@(posedge clk) disable iff (rst)
        diag_valid |-> ($past(state) == PH_DIAG));

endmodule

// File: tb/sim_tps_sequencer.sv
module sim_tps_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    localparam int P_BIT    = 8;
    localparam int P_INIT   = 6;
    localparam int P_SLEEP  = 40;
    localparam int P_WAKE   = 10;
    localparam int P_DIAG   = 12;
    localparam int P_SYNC   = 20;
    localparam int P_GAP    = 5;
    localparam int P_RXS    = 60;
    localparam int P_RXL    = 120;
    localparam int P_ABORT  = 15;
    localparam int P_MINLOW = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_line = 1'b0;
    logic       ant_fault = 1'b0;
    logic       start_found = 1'b0;
    logic [3:0] phase;
    logic [3:0] freq_code;
    logic       sync_out, fixed_thresh, test_follow, auto_tune, diag_valid;
    logic [6:0] div_factor;
    logic [7:0] diag_byte;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tps_sequencer #(
        .BIT_CYC(P_BIT), .INIT_CYC(P_INIT), .SLEEP_CYC(P_SLEEP), .WAKE_CYC(P_WAKE),
        .DIAG_CYC(P_DIAG), .SYNC_CYC(P_SYNC), .GAP_CYC(P_GAP), .RXS_CYC(P_RXS),
        .RXL_CYC(P_RXL), .ABORT_CYC(P_ABORT), .MINLOW_CYC(P_MINLOW)
    ) u0 (
        .clk(clk), .rst(rst), .ctl_line(ctl_line), .ant_fault(ant_fault),
        .start_found(start_found), .phase(phase), .freq_code(freq_code),
        .sync_out(sync_out), .fixed_thresh(fixed_thresh), .test_follow(test_follow),
        .div_factor(div_factor), .auto_tune(auto_tune), .diag_byte(diag_byte),
        .diag_valid(diag_valid)
    );

    // ---------------- behavioural reference model ----------------
    int m_ph, m_t, m_prev, m_code, m_sync, m_fix, m_test, m_dv, m_db;
    int m_found, m_arm, m_acnt, nph, lim;
    int m_bits[8];
    bit live = 1'b0;
    bit fall_seen;

    always @(posedge clk) begin
        live <= 1'b1;
        if (rst) begin
            m_ph = 2; m_t = 0; m_prev = 0; m_code = 0; m_sync = 0; m_fix = 0;
            m_test = 0; m_dv = 0; m_db = 0; m_found = 0; m_arm = 0; m_acnt = 0;
            foreach (m_bits[i]) m_bits[i] = 0;
        end else begin
            fall_seen = (m_prev == 1 && ctl_line == 1'b0);
            nph = m_ph;
            m_dv = (m_ph == 5 && m_t == P_DIAG - 1) ? 1 : 0;
            if (m_dv == 1) m_db = ant_fault ? 'hFF : 'hAF;
            case (m_ph)
                0: if (fall_seen) nph = 1;
                1: if (m_t == P_WAKE - 1) nph = 2;
                2: if (ctl_line) nph = 3; else if (m_t == P_SLEEP - 1) nph = 0;
                3: if (!ctl_line) nph = 4; else if (m_t == P_INIT - 1) nph = 5;
                4: begin
                    if (m_t % P_BIT == P_BIT / 2) m_bits[m_t / P_BIT] = int'(ctl_line);
                    if (m_t == 8 * P_BIT - 1) begin
                        m_code = m_bits[1] + 2 * m_bits[2] + 4 * m_bits[3] + 8 * m_bits[4];
                        m_sync = m_bits[5];
                        m_fix  = m_bits[6];
                        m_test = m_bits[7];
                        nph = 5;
                    end
                end
                5: if (m_t == (m_sync != 0 ? P_SYNC : P_DIAG) - 1) nph = 6;
                6: if (!ctl_line) nph = 7;
                7: if (ctl_line) nph = 8; else if (m_t == P_GAP - 1) nph = 9;
                8: if (!ctl_line && m_t == P_GAP - 1) nph = 9;
                9: begin
                    lim = (m_found != 0) ? P_RXL : P_RXS;
                    if ((m_arm != 0 && m_acnt == P_ABORT) || m_t == lim - 1) nph = 2;
                    if (start_found) m_found = 1;
                    if (m_arm == 0) begin
                        if (fall_seen) begin m_arm = 1; m_acnt = 1; end
                    end else if (ctl_line && m_acnt < P_MINLOW) begin
                        m_arm = 0; m_acnt = 0;
                    end else if (m_acnt != P_ABORT) begin
                        m_acnt = m_acnt + 1;
                    end
                end
                default: nph = 2;
            endcase
            if (m_ph != 9) begin m_found = 0; m_arm = 0; m_acnt = 0; end
            if (nph != m_ph || (m_ph == 8 && ctl_line)) m_t = 0;
            else m_t = m_t + 1;
            m_ph = nph;
            m_prev = int'(ctl_line);
        end
    end

    function automatic int exp_div(input int code);
        if (code >= 1 && code <= 11) return 113 + code;
        return 119;
    endfunction

    function automatic string phase_tag(input int ph);
        case (ph)
            0: return "R2";
            1: return "R3 R12";
            2: return "R1";
            3: return "R4";
            4: return "R5";
            5: return (m_sync != 0) ? "R8 R12" : "R7 R12";
            9: return (m_arm != 0) ? "R11" : "R10";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // compare on every clock, half a period after the edge
    always @(negedge clk) begin
        if (live) begin
            check(phase_tag(m_ph), "phase", int'(phase), m_ph);
            check("R5", "freq_code", int'(freq_code), m_code);
            check("R5", "sync_out", int'(sync_out), m_sync);
            check("R5", "fixed_thresh", int'(fixed_thresh), m_fix);
            check("R5", "test_follow", int'(test_follow), m_test);
            check("R6", "div_factor", int'(div_factor), exp_div(m_code));
            check("R6", "auto_tune", int'(auto_tune), (m_code == 15) ? 1 : 0);
            check("R7", "diag_valid", int'(diag_valid), m_dv);
            if (m_dv != 0) check("R7", "diag_byte", int'(diag_byte), m_db);
        end
    end

    // ---------------- stimulus ----------------
    task automatic hold(input logic v, input int n);
        ctl_line = v;
        repeat (n) @(negedge clk);
    endtask

    // word bits {test, fixed, sync, code[3:0]} = mode word bits 7..1
    task automatic write_mode(input logic [7:1] w);
        hold(1'b1, 3);
        hold(1'b0, P_BIT);
        for (int i = 1; i < 8; i++) hold(w[i], P_BIT);
        ctl_line = 1'b1;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog expired actual=%0d expected=finished", WATCHDOG);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;                          // R1 reset values compared above
        // R2 sleep entry, R3 wake-up with R12 toggles ignored
        hold(1'b0, 50);
        hold(1'b1, 5);
        hold(1'b0, 3);
        hold(1'b1, 2);
        hold(1'b0, 15);
        // R4 plain charge, R7 good antenna, R9 gap, R10 short timeout
        ant_fault = 1'b0;
        hold(1'b1, 30);
        hold(1'b0, 80);
        // R5 code 5, fixed threshold; R7 faulty antenna; R9 write/program
        write_mode(7'b0100101);
        ant_fault = 1'b1;
        hold(1'b1, 20);
        ant_fault = 1'b0;
        hold(1'b0, 2);
        hold(1'b1, 3);
        hold(1'b0, 2);
        hold(1'b1, 2);
        hold(1'b0, 8);
        start_found = 1'b1;                  // R10 long timeout
        hold(1'b0, 1);
        start_found = 1'b0;
        hold(1'b0, 130);
        // R6 auto tune, R8 sync diagnosis with R12 toggles, R11 cancel then abort
        write_mode(7'b1011111);
        hold(1'b1, 5);
        hold(1'b0, 3);
        hold(1'b1, 17);
        hold(1'b0, 8);
        start_found = 1'b1;
        hold(1'b0, 1);
        start_found = 1'b0;
        hold(1'b1, 2);
        hold(1'b0, 3);
        hold(1'b1, 2);
        hold(1'b0, 25);
        // R6 code 11 -> 124; R11 abort kept after a late high
        write_mode(7'b0001011);
        hold(1'b1, 20);
        hold(1'b0, 8);
        hold(1'b1, 2);
        hold(1'b0, 8);
        hold(1'b1, 40);
        hold(1'b0, 80);
        // R6 code 1 -> 114 and undefined code 12 -> 119
        write_mode(7'b0000001);
        hold(1'b1, 20);
        hold(1'b0, 80);
        write_mode(7'b0001100);
        hold(1'b1, 20);
        hold(1'b0, 80);
        finish_run();
    end

endmodule